// File: doc/BRIEF.md
# Key-Protected Software Reset Control Register

This block is a memory-mapped control register that guards a software reset bit and the write enable of a neighbouring configuration register behind an unlock key. Software writes the unlock value into the low half-word of the control register. The key field then reads back as a fixed "open" token. Exactly one protected write is accepted after that: either a control-register write that may request a reset, or a write to the neighbouring configuration register. Any such write closes the lock again, so every protected access needs its own unlock write first.

The bus side is a single-cycle port. A write strobe, a one-bit register select and a 32-bit write word are sampled on the clock edge. The read word is produced combinationally for the selected register. The block drives two outputs. One is a one-cycle software reset request. The other is a write enable for the neighbouring configuration register, which is stored outside this block. The block does not generate the reset itself.

Top module: `keyed_rst_ctrl`

## Requirements
- R1: After synchronous reset the block is locked. The control register reads 0x0001_0003: bit 16 is 1, the key field (bits 15:0) holds the locked token 0x0003, and bits 31:17 are 0. Neither `swrst_req` nor `cfg_wr_en` is asserted.
- R2: A write to the control register (`bus_sel`=0) whose bits 15:0 equal 0x5A69 unlocks the block. From the next cycle the key field reads the open token 0x000C.
- R3: A control-register write with any other value in bits 15:0 leaves a locked block locked, and the key field still reads 0x0003. This includes writing 0x000C directly.
- R4: While the block is locked, a control-register write with bit 16 = 0 raises no software reset request.
- R5: While the block is locked, a write with `bus_sel`=1 does not assert `cfg_wr_en`.
- R6: While the block is unlocked, a control-register write whose bits 15:0 are not the key and whose bit 16 = 0 raises `swrst_req` for exactly the one cycle after the write edge. During that cycle bit 16 reads 0; afterwards it reads 1 again.
- R7: While the block is unlocked, a write with `bus_sel`=1 asserts `cfg_wr_en` combinationally during that write cycle.
- R8: Any write with `bus_sel`=1, and any control-register write that does not carry the key, leaves the block locked afterwards (key field 0x0003). This holds whether or not the write was accepted, and it includes a wrong key written while the block is unlocked.
- R9: A key write is only an unlock attempt. Its bit 16 is not applied, so a key write with bit 16 = 0 raises no reset request.
- R10: Reading with `bus_sel`=1 returns 0. Control-register bits 31:17 always read 0.
- R11: An accepted control-register write with bit 16 = 1 raises no request and still relocks the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_sel | input | 1 | Register select: 0 = control register, 1 = neighbouring configuration register |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word for the selected register |
| swrst_req | output | 1 | One-cycle software reset request |
| cfg_wr_en | output | 1 | Write enable for the neighbouring configuration register |

## Verification
Two functions can fall in the same write cycle: unlocking and a reset request. A key write that also carries bit 16 = 0 provokes this, and the bench judges that the lock opens while no request pulse follows. The second collision is acceptance and relock: a single unlocked write must both take effect (a pulse, or `cfg_wr_en`) and close the lock. The bench checks this by attempting an immediate second protected write, which must be refused. A cycle-by-cycle behavioural model compares the read word and both outputs on every clock.

// File: rtl/krc_pkg.sv
package krc_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned KEY_W    = 16;
    localparam int unsigned SWRST_BIT = 16;

    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h5A69;
    localparam logic [KEY_W-1:0] TOKEN_OPEN = 16'h000C;
    localparam logic [KEY_W-1:0] TOKEN_SHUT = 16'h0003;

    typedef enum logic {
        LK_SHUT = 1'b0,
        LK_OPEN = 1'b1
    } lock_e;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_CFG  = 1'b1
    } sel_e;

    typedef struct packed {
        logic              wr;
        sel_e              sel;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic logic carries_key(input logic [DATA_W-1:0] d);
        return d[KEY_W-1:0] == UNLOCK_KEY;
    endfunction

    function automatic logic [KEY_W-1:0] key_token(input lock_e s);
        return (s == LK_OPEN) ? TOKEN_OPEN : TOKEN_SHUT;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input logic rst_bit,
                                                    input lock_e s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[SWRST_BIT]   = rst_bit;
        w[KEY_W-1:0]   = key_token(s);
        return w;
    endfunction

endpackage

// File: rtl/krc_lock.sv
module krc_lock
    import krc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  key_hit,
    input  logic  any_wr,
    output lock_e state
);

    always_ff @(posedge clk) begin
        if (rst)          state <= LK_SHUT;
        else if (key_hit) state <= LK_OPEN;
        else if (any_wr)  state <= LK_SHUT;
    end

    // R2: a key write opens the lock
    a_r2_key_opens: assert property (@(posedge clk) disable iff (rst)
        key_hit |=> state == LK_OPEN);

    // R8: any other write closes it
    a_r8_write_relocks: assert property (@(posedge clk) disable iff (rst)
        (any_wr && !key_hit) |=> state == LK_SHUT);

    // R3: without a key write a closed lock stays closed
    a_r3_stays_shut: assert property (@(posedge clk) disable iff (rst)
        (state == LK_SHUT && !key_hit) |=> state == LK_SHUT);

endmodule

// File: rtl/krc_swrst.sv
module krc_swrst
    import krc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr_hit,
    output logic bit_q,
    output logic req
);

    always_ff @(posedge clk) begin
        if (rst)          bit_q <= 1'b1;
        else if (clr_hit) bit_q <= 1'b0;
        else              bit_q <= 1'b1;
    end

    assign req = ~bit_q;

    // R6: the request lasts exactly one cycle when not re-triggered
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (req && !clr_hit) |=> !req);

endmodule

// File: rtl/keyed_rst_ctrl.sv
module keyed_rst_ctrl
    import krc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              swrst_req,
    output logic              cfg_wr_en
);

    bus_req_t breq;
    lock_e    lock_state;
    logic     key_hit;
    logic     ctrl_wr;
    logic     clr_hit;
    logic     rst_bit;

    always_comb begin
        breq.wr   = bus_wr;
        breq.sel  = sel_e'(bus_sel);
        breq.data = bus_wdata;
    end

    assign ctrl_wr   = breq.wr && (breq.sel == SEL_CTRL);
    assign key_hit   = ctrl_wr && carries_key(breq.data);
    assign clr_hit   = ctrl_wr && !key_hit && (lock_state == LK_OPEN)
                       && !breq.data[SWRST_BIT];
    assign cfg_wr_en = breq.wr && (breq.sel == SEL_CFG) && (lock_state == LK_OPEN);

    krc_lock u_lock (
        .clk     (clk),
        .rst     (rst),
        .key_hit (key_hit),
        .any_wr  (breq.wr),
        .state   (lock_state)
    );

    krc_swrst u_swrst (
        .clk     (clk),
        .rst     (rst),
        .clr_hit (clr_hit),
        .bit_q   (rst_bit),
        .req     (swrst_req)
    );

    always_comb begin
        if (breq.sel == SEL_CTRL) bus_rdata = pack_ctrl(rst_bit, lock_state);
        else                      bus_rdata = '0;
    end

    // R9: a key write never yields a request
    a_r9_key_no_pulse: assert property (@(posedge clk) disable iff (rst)
        key_hit |=> !swrst_req);

    // R4: a write while locked yields no request
    a_r4_locked_no_pulse: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && lock_state == LK_SHUT) |=> !swrst_req);

    // R5 / R7: the companion enable appears only when open
    a_r5_cfg_needs_open: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en |-> lock_state == LK_OPEN);

    // R10: companion address reads zero
    always_comb begin
        if (!rst && bus_sel == 1'b1)
            a_r10_cfg_reads_zero: assert (bus_rdata == '0);
    end

endmodule

// File: tb/keyed_rst_ctrl_bench.sv
module keyed_rst_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic        bus_sel;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        swrst_req;
    logic        cfg_wr_en;

    int    n_checks = 0;
    int    n_fails  = 0;
    string phase    = "R1 reset";

    // behavioural reference state
    bit ref_open    = 0;
    bit ref_pending = 0;

    always #2 clk = ~clk;

    keyed_rst_ctrl u_keyed_rst_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .swrst_req (swrst_req),
        .cfg_wr_en (cfg_wr_en)
    );

    // reference update on each edge
    always @(posedge clk) begin
        if (rst) begin
            ref_open    = 0;
            ref_pending = 0;
        end else begin
            ref_pending = 0;
            if (bus_wr) begin
                if (!bus_sel && bus_wdata[15:0] == 16'h5A69) begin
                    ref_open = 1;
                end else begin
                    if (!bus_sel && ref_open && !bus_wdata[16]) ref_pending = 1;
                    ref_open = 0;
                end
            end
        end
    end

    // comparison every cycle, away from the active edge
    always @(negedge clk) begin
        logic [31:0] exp_rd;
        logic        exp_cfg;
        if (!rst) begin
            exp_cfg = bus_wr && bus_sel && ref_open;
            if (bus_sel) exp_rd = 32'h0;
            else exp_rd = {15'h0, ~ref_pending, (ref_open ? 16'h000C : 16'h0003)};
            n_checks++;
            if (bus_rdata !== exp_rd) begin
                n_fails++;
                $display("FAIL %s: rdata %h expected %h", phase, bus_rdata, exp_rd);
            end
            n_checks++;
            if (swrst_req !== ref_pending) begin
                n_fails++;
                $display("FAIL %s: swrst_req %b expected %b", phase, swrst_req, ref_pending);
            end
            n_checks++;
            if (cfg_wr_en !== exp_cfg) begin
                n_fails++;
                $display("FAIL %s: cfg_wr_en %b expected %b", phase, cfg_wr_en, exp_cfg);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            bus_wr = 0; bus_sel = 0; bus_wdata = '0;
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1; bus_sel = sel; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0; bus_sel = 0; bus_wdata = '0;
    endtask

    task automatic direct(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 20000) begin
                n_fails++;
                $display("FAIL watchdog expired");
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        rst = 1; bus_wr = 0; bus_sel = 0; bus_wdata = '0;
        idle(3);
        rst = 0;
        @(negedge clk);
        direct("R1 reset readback", bus_rdata, 32'h0001_0003);
        direct("R1 no request", {31'h0, swrst_req}, 32'h0);

        phase = "R3 wrong keys while locked";
        wr(0, 32'h0000_000C);
        wr(0, 32'h0001_5A68);
        @(negedge clk);
        direct("R3 still locked", bus_rdata, 32'h0001_0003);

        phase = "R4 locked reset write";
        wr(0, 32'h0000_1234);
        idle(2);

        phase = "R5 locked companion write";
        wr(1, 32'hFFFF_FFFF);
        phase = "R10 companion read";
        @(posedge clk); #1; bus_sel = 1;
        @(negedge clk);
        direct("R10 companion reads zero", bus_rdata, 32'h0);
        idle(1);

        phase = "R2 unlock";
        wr(0, 32'h0001_5A69);
        @(negedge clk);
        direct("R2 open token", bus_rdata, 32'h0001_000C);

        phase = "R6 accepted reset";
        @(posedge clk); #1;
        bus_wr = 1; bus_sel = 0; bus_wdata = 32'h0000_0000;
        @(posedge clk); #1;
        bus_wr = 0; bus_wdata = '0;
        @(negedge clk);
        direct("R6 pulse high", {31'h0, swrst_req}, 32'h1);
        direct("R6 bit16 reads 0", bus_rdata, 32'h0000_0003);
        @(negedge clk);
        direct("R6 pulse ended", {31'h0, swrst_req}, 32'h0);
        direct("R8 relocked after reset write", bus_rdata, 32'h0001_0003);

        phase = "R8 second write refused";
        wr(0, 32'h0000_0000);
        idle(2);

        phase = "R9 key with bit16 low";
        wr(0, 32'h0000_5A69);
        @(negedge clk);
        direct("R9 no pulse", {31'h0, swrst_req}, 32'h0);
        direct("R9 unlocked", bus_rdata, 32'h0001_000C);

        phase = "R7 accepted companion write";
        @(posedge clk); #1;
        bus_wr = 1; bus_sel = 1; bus_wdata = 32'hA5A5_0000;
        @(negedge clk);
        direct("R7 enable during write", {31'h0, cfg_wr_en}, 32'h1);
        idle(1);
        phase = "R8 relock after companion";
        wr(1, 32'h1);
        @(negedge clk);
        direct("R8 locked", bus_rdata, 32'h0001_0003);

        phase = "R11 accepted write bit16 high";
        wr(0, 32'h0000_5A69);
        wr(0, 32'h0001_0000);
        @(negedge clk);
        direct("R11 no pulse, relocked", bus_rdata, 32'h0001_0003);

        phase = "R8 wrong key while open";
        wr(0, 32'h0000_5A69);
        wr(0, 32'hFFFE_1111);
        idle(2);
        phase = "R10 upper bits zero";
        @(negedge clk);
        direct("R10 upper bits", {16'h0, bus_rdata[31:16]}, 32'h1);

        phase = "mixed sequence";
        for (int i = 0; i < 40; i++) begin
            wr(i[0], (i % 3 == 0) ? {15'h0, i[1], 16'h5A69} : {16'h0, i[3:0], 12'h0});
        end
        idle(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule